// File: doc/BRIEF.md
# Shared-Medium Retry and Backoff Controller

This block arbitrates one station's access to a shared half-duplex line that uses carrier sense with collision detection. A frame request is held off while the line is busy. Once the line is seen clear, the block tells the frame transmitter to start. If a collision is reported while the frame is going out, the block holds a jam interval so that other stations see the collision. It then tells the transmitter to abandon the frame and waits a random number of slot times before it tries again.

The random wait is truncated binary exponential backoff. After the n-th collision on the same frame, a slot count is drawn uniformly from 0 to 2^min(n, BACKOFF_LIMIT) - 1. The draw is taken from a free-running LFSR. When the frame goes out cleanly, the block pulses a completion flag. When the last allowed attempt also collides, it pulses a failure flag and gives up on the frame. In both cases the attempt history is cleared.

Timing is counted in clock cycles. JAM_CYCLES sets the jam hold, which is 80 ns at the target clock. SLOT_CYCLES sets the backoff slot, which by default is 512 bit times at 10 Mbit/s with a 250 MHz clock.

Top module: `csma_retry_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards until a request is accepted, tx_start_o, jam_o, tx_abort_o, done_o and fail_o are all low.
- R2: tx_req_i is sampled only while the block is idle. Once a request has been accepted, tx_start_o pulses for one cycle, and only in the cycle after a clock edge at which medium_busy_i was low. With the line already clear, the pulse comes two cycles after the request. While the line stays busy, no start is given.
- R3: A collision_i sampled high during transmission raises jam_o in the next cycle. jam_o then stays high for exactly JAM_CYCLES consecutive cycles. tx_abort_o pulses for one cycle in the first cycle after jam_o falls.
- R4: After the n-th collision on a frame, the next tx_start_o on a clear line comes r*SLOT_CYCLES + 2 cycles after the tx_abort_o pulse. Here r is a whole number from 0 to 2^min(n, BACKOFF_LIMIT) - 1.
- R5: If the collision happens on attempt MAX_ATTEMPTS, fail_o pulses in the same cycle as tx_abort_o. No further start follows for that frame, and the attempt count is cleared, so the next frame's first backoff range is 0 to 1 slots.
- R6: tx_end_i sampled high during transmission with no collision gives a one-cycle done_o pulse in the next cycle. It also clears the attempt count.
- R7: If collision_i and tx_end_i are sampled high at the same edge during transmission, the collision is handled and done_o stays low.
- R8: collision_i and tx_end_i are ignored outside transmission: they raise neither jam_o nor done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_i | input | 1 | Frame ready to send, sampled while idle |
| medium_busy_i | input | 1 | Carrier present on the line |
| collision_i | input | 1 | Collision seen on the line |
| tx_end_i | input | 1 | Frame transmitter finished the frame |
| tx_start_o | output | 1 | One-cycle pulse: begin sending the frame |
| jam_o | output | 1 | High while the jam pattern must be driven |
| tx_abort_o | output | 1 | One-cycle pulse: abandon the current attempt |
| done_o | output | 1 | One-cycle pulse: frame sent without collision |
| fail_o | output | 1 | One-cycle pulse: frame dropped after the attempt limit |

## Verification
If the attempt counter is corrupted, two things can show at the ports. A frame may fail after the wrong number of collisions. Or a backoff gap may fall outside the allowed window, or off the slot grid; this is visible at the first restart after the faulty collision. A jam counter that is off by one changes the width of jam_o on the very first collision, and the tx_abort_o pulse then comes one cycle early or late. A wrong state decode shows up at once: a start during a busy line, or a jam or done reacting to inputs outside transmission.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_TX,
    ST_JAM,
    ST_BACKOFF
  } csma_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   SEED = 'hACE1,
  parameter logic [W-1:0]   TAPS = 'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] lfsr_o
);
  logic [W-1:0] q;

  // Galois form, shifts right every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= (q >> 1) ^ ({W{q[0]}} & TAPS);
  end

  assign lfsr_o = q;
endmodule

// File: rtl/csma_backoff_timer.sv
module csma_backoff_timer #(
  parameter int unsigned SLOT_CYCLES = 12800,
  parameter int unsigned SLOT_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              expired_o
);
  localparam int unsigned CYC_W = $clog2(SLOT_CYCLES + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);

  logic [SLOT_W-1:0] slots_q;
  logic [CYC_W-1:0]  cyc_q;

  // slot count and in-slot cycle count nested: no multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_q <= '0;
      cyc_q   <= '0;
    end else if (load_i) begin
      slots_q <= slots_i;
      cyc_q   <= CYC_LAST;
    end else if (slots_q != '0) begin
      if (cyc_q == '0) begin
        slots_q <= slots_q - 1'b1;
        cyc_q   <= CYC_LAST;
      end else begin
        cyc_q <= cyc_q - 1'b1;
      end
    end
  end

  assign expired_o = (slots_q == '0);
endmodule

// File: rtl/csma_retry_ctrl.sv
module csma_retry_ctrl
  import csma_pkg::*;
#(
  parameter int unsigned         JAM_CYCLES    = 20,
  parameter int unsigned         SLOT_CYCLES   = 12800,
  parameter int unsigned         MAX_ATTEMPTS  = 16,
  parameter int unsigned         BACKOFF_LIMIT = 10,
  parameter int unsigned         LFSR_W        = 16,
  parameter logic [LFSR_W-1:0]   LFSR_SEED     = 'hACE1,
  parameter logic [LFSR_W-1:0]   LFSR_TAPS     = 'hB400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_req_i,
  input  logic medium_busy_i,
  input  logic collision_i,
  input  logic tx_end_i,
  output logic tx_start_o,
  output logic jam_o,
  output logic tx_abort_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned JAM_W = $clog2(JAM_CYCLES + 1);
  localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS);
  localparam logic [JAM_W-1:0] JAM_LAST = JAM_W'(JAM_CYCLES - 1);

  csma_state_e              state_q;
  logic [ATT_W-1:0]         attempts_q;
  logic [JAM_W-1:0]         jam_cnt_q;
  logic [LFSR_W-1:0]        lfsr_q;
  logic [BACKOFF_LIMIT-1:0] slot_mask;
  logic [BACKOFF_LIMIT-1:0] slot_draw;
  logic                     jam_end;
  logic                     bo_expired;
  logic start_q, abort_q, done_q, fail_q;

  csma_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lfsr_o (lfsr_q)
  );

  // mask width is min(attempts, limit): bit i set when i < attempts
  always_comb begin
    for (int i = 0; i < BACKOFF_LIMIT; i++) begin
      slot_mask[i] = (32'(i) < 32'(attempts_q));
    end
  end

  assign slot_draw = lfsr_q[BACKOFF_LIMIT-1:0] & slot_mask;
  assign jam_end   = (state_q == ST_JAM) && (jam_cnt_q == '0);

  csma_backoff_timer #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .SLOT_W      (BACKOFF_LIMIT)
  ) u_backoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (jam_end),
    .slots_i   (slot_draw),
    .expired_o (bo_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      attempts_q <= '0;
      jam_cnt_q  <= '0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tx_req_i) state_q <= ST_DEFER;
        ST_DEFER: begin
          if (!medium_busy_i) begin
            state_q    <= ST_TX;
            start_q    <= 1'b1;
            attempts_q <= attempts_q + 1'b1;
          end
        end
        ST_TX: begin
          if (collision_i) begin
            state_q   <= ST_JAM;
            jam_cnt_q <= JAM_LAST;
          end else if (tx_end_i) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            attempts_q <= '0;
          end
        end
        ST_JAM: begin
          if (jam_cnt_q == '0) begin
            abort_q <= 1'b1;
            if (attempts_q == ATT_LAST) begin
              fail_q     <= 1'b1;
              attempts_q <= '0;
              state_q    <= ST_IDLE;
            end else begin
              state_q <= ST_BACKOFF;
            end
          end else begin
            jam_cnt_q <= jam_cnt_q - 1'b1;
          end
        end
        ST_BACKOFF: if (bo_expired) state_q <= ST_DEFER;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_start_o = start_q;
  assign jam_o      = (state_q == ST_JAM);
  assign tx_abort_o = abort_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/csma_retry_ctrl_chk.sv
module csma_retry_ctrl_chk
  import csma_pkg::*;
#(
  parameter int unsigned MAX_ATTEMPTS = 16,
  parameter int unsigned ATT_W        = 5,
  parameter int unsigned LFSR_W       = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              medium_busy_i,
  input logic              collision_i,
  input logic              tx_end_i,
  input logic              tx_start_o,
  input logic              jam_o,
  input logic              tx_abort_o,
  input logic              done_o,
  input logic              fail_o,
  input csma_state_e       state_q,
  input logic [ATT_W-1:0]  attempts_q,
  input logic [LFSR_W-1:0] lfsr_q
);
  a_r2_start_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(!medium_busy_i));

  a_r3_jam_follows_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && collision_i) |=> jam_o);

  a_r3_abort_after_jam: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> ($past(jam_o) && !jam_o));

  a_r4_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  a_r5_fail_with_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> tx_abort_o);

  a_r5_attempts_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(attempts_q) <= MAX_ATTEMPTS);

  a_r6_done_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!tx_abort_o && !fail_o && !jam_o));

  a_r7_col_beats_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && collision_i && tx_end_i) |=> !done_o);

  a_r8_no_jam_outside_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_TX && state_q != ST_JAM) |=> !jam_o);
endmodule

bind csma_retry_ctrl csma_retry_ctrl_chk #(
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .ATT_W        (ATT_W),
  .LFSR_W       (LFSR_W)
) u_chk (.*);

// File: tb/csma_retry_ctrl_test.sv
module csma_retry_ctrl_test;
  localparam int JAM   = 4;
  localparam int SLOT  = 3;
  localparam int MAXA  = 16;
  localparam int LIMIT = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_req_i = 1'b0, medium_busy_i = 1'b0, collision_i = 1'b0, tx_end_i = 1'b0;
  logic tx_start_o, jam_o, tx_abort_o, done_o, fail_o;

  always #2 clk = ~clk;

  csma_retry_ctrl #(
    .JAM_CYCLES    (JAM),
    .SLOT_CYCLES   (SLOT),
    .MAX_ATTEMPTS  (MAXA),
    .BACKOFF_LIMIT (LIMIT)
  ) uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .tx_req_i      (tx_req_i),
    .medium_busy_i (medium_busy_i),
    .collision_i   (collision_i),
    .tx_end_i      (tx_end_i),
    .tx_start_o    (tx_start_o),
    .jam_o         (jam_o),
    .tx_abort_o    (tx_abort_o),
    .done_o        (done_o),
    .fail_o        (fail_o)
  );

  typedef enum int {EV_START, EV_ABORT, EV_DONE, EV_FAIL} ev_e;
  typedef struct {ev_e kind; int ncol;} exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pop_ev(input ev_e kind, output exp_t it);
    if (q.size() == 0) begin
      check(1'b0, "R8", "unexpected event", int'(kind), -1);
      it.kind = kind;
      it.ncol = 0;
    end else begin
      it = q.pop_front();
      check(it.kind == kind, "R3", "event order", int'(kind), int'(it.kind));
    end
  endtask

  // monitor
  bit prev_busy = 1'b0, prev_jam = 1'b0;
  int jam_run = 0, t_abort = 0;
  always @(negedge clk) begin
    exp_t it;
    if (rst_ni) begin
      if (jam_o) jam_run++;
      if (prev_jam && !jam_o) begin
        check(jam_run == JAM, "R3", "jam width", jam_run, JAM);
        check(tx_abort_o == 1'b1, "R3", "abort after jam", int'(tx_abort_o), 1);
        jam_run = 0;
      end
      if (tx_start_o) begin
        pop_ev(EV_START, it);
        check(!prev_busy, "R2", "start on busy line", int'(prev_busy), 0);
        if (it.ncol > 0) begin
          int d, lim;
          d   = cyc - t_abort - 2;
          lim = (1 << (it.ncol > LIMIT ? LIMIT : it.ncol)) - 1;
          check(d >= 0 && d % SLOT == 0, "R4", "gap off slot grid", d, 0);
          check(d / SLOT <= lim, "R4", "slots beyond range", d / SLOT, lim);
        end
      end
      if (tx_abort_o) begin
        pop_ev(EV_ABORT, it);
        t_abort = cyc;
      end
      if (done_o) pop_ev(EV_DONE, it);
      if (fail_o) pop_ev(EV_FAIL, it);
    end
    prev_busy = medium_busy_i;
    prev_jam  = jam_o;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!tx_start_o);
  endtask

  task automatic push(input ev_e k, input int n);
    exp_t it;
    it.kind = k;
    it.ncol = n;
    q.push_back(it);
  endtask

  // driver: ncol collisions, then success or failure at MAXA
  task automatic send_frame(input int ncol, input bit both_first);
    for (int a = 0; a < ncol; a++) begin
      push(EV_START, a);
      push(EV_ABORT, 0);
    end
    if (ncol >= MAXA) push(EV_FAIL, 0);
    else begin
      push(EV_START, ncol);
      push(EV_DONE, 0);
    end
    tick(); tx_req_i = 1'b1;
    tick(); tx_req_i = 1'b0;
    for (int a = 0; a < ncol; a++) begin
      wait_start();
      collision_i = 1'b1;
      tx_end_i    = (a == 0) && both_first;
      tick();
      collision_i = 1'b0;
      tx_end_i    = 1'b0;
      if (a == 0 && both_first) begin
        @(negedge clk);
        check(jam_o && !done_o, "R7", "collision must win", int'(done_o), 0);
      end
    end
    if (ncol < MAXA) begin
      wait_start();
      tx_end_i = 1'b1;
      tick();
      tx_end_i = 1'b0;
      @(negedge clk);
      check(done_o == 1'b1, "R6", "done pulse", int'(done_o), 1);
    end else begin
      do @(negedge clk); while (!fail_o);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        check(!tx_start_o, "R5", "start after failure", int'(tx_start_o), 0);
      end
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check({tx_start_o, jam_o, tx_abort_o, done_o, fail_o} == 5'b0, "R1",
          "outputs in reset", int'({tx_start_o, jam_o, tx_abort_o, done_o, fail_o}), 0);
    tick(); rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check({tx_start_o, jam_o, tx_abort_o, done_o, fail_o} == 5'b0, "R1",
            "outputs idle", int'({tx_start_o, jam_o, tx_abort_o, done_o, fail_o}), 0);
    end

    // R8 collision and end while idle
    @(negedge clk);
    collision_i = 1'b1;
    tx_end_i    = 1'b1;
    tick();
    collision_i = 1'b0;
    tx_end_i    = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!jam_o && !done_o, "R8", "reaction outside tx", int'({jam_o, done_o}), 0);
    end

    // R2 busy line holds off start, exact latency on release
    push(EV_START, 0);
    push(EV_DONE, 0);
    tick(); medium_busy_i = 1'b1; tx_req_i = 1'b1;
    tick(); tx_req_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!tx_start_o, "R2", "start while busy", int'(tx_start_o), 0);
    end
    tick(); medium_busy_i = 1'b0;
    @(negedge clk);
    check(!tx_start_o, "R2", "start too early", int'(tx_start_o), 0);
    @(negedge clk);
    check(tx_start_o == 1'b1, "R2", "start after release", int'(tx_start_o), 1);
    tx_end_i = 1'b1;
    tick();
    tx_end_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1, "R6", "done after busy wait", int'(done_o), 1);
    while (q.size() != 0) @(negedge clk);

    // R6 clean frame on clear line
    send_frame(0, 1'b0);
    // R3 R4 several collisions then success
    send_frame(3, 1'b0);
    send_frame(6, 1'b0);
    // R7 collision and end at the same edge
    send_frame(2, 1'b1);
    // R5 attempt limit, truncation beyond LIMIT collisions
    send_frame(MAXA, 1'b0);
    // R5 count cleared: first backoff range is 0..1
    send_frame(1, 1'b0);

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R6", "pending expectations", q.size(), 0);
    finish_run();
  end
endmodule